// File: doc/BRIEF.md
# BCD Time Calendar Counter

This block keeps wall-clock time as a chain of binary-coded-decimal counters. The chain covers seconds, minutes, hours, day of week, day of month, month and a two-digit year, and a century flag sits above the year. The chain advances once for each one-cycle pulse on `tick_1hz`, which comes from an external crystal divider. Software reaches the block through a byte-wide register write port and a combinational register read port that share one small address map. One bit in that map stops the count. Two other bits select whether the year wrap flips the century flag.

A serial-bus front end reads several registers in a row. While it does this it raises `rd_busy`. If a tick lands while `rd_busy` is high, the block keeps advancing its true count. The copy that the read port shows stays frozen for a hold-off window, so a multi-byte read never sees a carry ripple part way through. The window is `HOLD_CNT` pulses of `msec_ce`, a slower clock enable; 250 pulses of a 1 kHz enable give a quarter second. When the window ends, the visible copy catches up with the true time. Every tick that arrived during the window is therefore included.

Any write to a time register also raises `phase_rst` in the same cycle. The divider uses it to restart its sub-second phase, so the next tick comes one full second after the load.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, addresses 0 to 6 read 00, 00, 00, 01, 01, 01, 00 (hex). The stop, century-enable and century bits are 0.
- R2: Register map. Address 0 holds {stop, sec[6:0]}. Address 1 holds {0, min[6:0]}. Address 2 holds {cen_en, cen, hour[5:0]}. Address 3 holds {00000, dow[2:0]}. Address 4 holds {00, date[5:0]}. Address 5 holds {000, month[4:0]}. Address 6 holds year[7:0]. Unused upper bits read 0. Address 7 reads 00, and writes to it change nothing.
- R3: On each counted tick, seconds and minutes count 00 to 59 in BCD and wrap to 00, each carrying into the next field. Hours count 00 to 23 and carry into the day fields at the wrap.
- R4: At the hour wrap, day of week steps 1 to 7 and wraps to 1. The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, and 31 for the other months except February.
- R5: February ends on 29 when the BCD year, read as a decimal number, is divisible by 4 (00 included). Otherwise it ends on 28.
- R6: The month wraps 12 to 01 and carries into the year. The year wraps 99 to 00.
- R7: At the year wrap the century bit (address 2, bit 6) inverts if century-enable (address 2, bit 7) is 1. If century-enable is 0, the century bit never changes.
- R8: While the stop bit (address 0, bit 7) is 1, ticks are ignored and no field advances.
- R9: A tick that arrives while `rd_busy` is high freezes the visible registers for `HOLD_CNT` pulses of `msec_ce`. The true count still advances on every tick, including ticks that arrive during the freeze. All of them appear once the freeze ends.
- R10: A register write takes priority over a tick in the same cycle, and that tick is dropped. `phase_rst` is high exactly while a write to addresses 0 to 6 is presented.
- R11: When no freeze is active, a counted tick becomes visible on the read port two clock edges after the tick cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| msec_ce | input | 1 | Clock enable that times the read hold-off |
| rd_busy | input | 1 | High while a multi-byte read is in progress |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data from the visible copy |
| phase_rst | output | 1 | Restarts the divider's sub-second phase on a time write |

## Verification
A wrong carry condition inside the chain shows up on the read port on the very tick that crosses the broken boundary. The bench therefore loads times that sit one tick before each wrap and compares all seven registers against a decimal reference model. A fault in the freeze counter shows as a visible copy that updates too early or never catches up. This is checked one pulse before and one pulse after the window closes. A fault in the century or stop logic stays hidden until a year wrap or a tick arrives, so each of those cases is driven on purpose.

// File: rtl/rtc_bcd_calendar.sv
`timescale 1ns/1ps
module rtc_bcd_calendar #(
  parameter int HOLD_CNT = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       msec_ce,
  input  logic       rd_busy,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       phase_rst
);
  localparam int HW = $clog2(HOLD_CNT + 1);

  logic       st_q, ceb_q, cb_q;
  logic [6:0] sec_q, min_q;
  logic [5:0] hr_q, date_q;
  logic [2:0] dow_q;
  logic [4:0] mon_q;
  logic [7:0] yr_q;

  logic       v_cb;
  logic [6:0] v_sec, v_min;
  logic [5:0] v_hr, v_date;
  logic [2:0] v_dow;
  logic [4:0] v_mon;
  logic [7:0] v_yr;

  logic [HW-1:0] hold_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {4'(v[7:4] + 4'd1), 4'h0} : {v[7:4], 4'(v[3:0] + 4'd1)};
  endfunction

  logic       adv, c_s, c_m, c_h, c_d, c_mo, c_y, leap;
  logic [7:0] ybin;
  logic [5:0] last_day;

  assign adv  = tick_1hz && !st_q && !wr_en;
  assign c_s  = sec_q >= 7'h59;
  assign c_m  = min_q >= 7'h59;
  assign c_h  = hr_q >= 6'h23;
  assign c_mo = mon_q >= 5'h12;
  assign c_y  = yr_q >= 8'h99;
  assign ybin = 8'(yr_q[7:4]) * 8'd10 + 8'(yr_q[3:0]);
  assign leap = ybin[1:0] == 2'b00;
  assign c_d  = date_q >= last_day;
  assign phase_rst = wr_en && (wr_addr != 3'd7);

  always_comb begin
    case (mon_q)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 1'b0; ceb_q <= 1'b0; cb_q <= 1'b0;
      sec_q <= '0; min_q <= '0; hr_q <= '0;
      dow_q <= 3'd1; date_q <= 6'h01; mon_q <= 5'h01; yr_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin st_q <= wr_data[7]; sec_q <= wr_data[6:0]; end
        3'd1: min_q <= wr_data[6:0];
        3'd2: begin ceb_q <= wr_data[7]; cb_q <= wr_data[6]; hr_q <= wr_data[5:0]; end
        3'd3: dow_q <= wr_data[2:0];
        3'd4: date_q <= wr_data[5:0];
        3'd5: mon_q <= wr_data[4:0];
        3'd6: yr_q <= wr_data;
        default: ;
      endcase
    end else if (adv) begin
      sec_q <= c_s ? 7'h00 : 7'(bcd_inc({1'b0, sec_q}));
      if (c_s)
        min_q <= c_m ? 7'h00 : 7'(bcd_inc({1'b0, min_q}));
      if (c_s && c_m)
        hr_q <= c_h ? 6'h00 : 6'(bcd_inc({2'b0, hr_q}));
      if (c_s && c_m && c_h) begin
        dow_q  <= (dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1;
        date_q <= c_d ? 6'h01 : 6'(bcd_inc({2'b0, date_q}));
        if (c_d) begin
          mon_q <= c_mo ? 5'h01 : 5'(bcd_inc({3'b0, mon_q}));
          if (c_mo) begin
            yr_q <= c_y ? 8'h00 : bcd_inc(yr_q);
            if (c_y && ceb_q) cb_q <= ~cb_q;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_q <= '0;
    else if (adv && rd_busy && hold_q == '0)
      hold_q <= HW'(HOLD_CNT);
    else if (hold_q != '0 && msec_ce)
      hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_cb <= 1'b0; v_sec <= '0; v_min <= '0; v_hr <= '0;
      v_dow <= 3'd1; v_date <= 6'h01; v_mon <= 5'h01; v_yr <= '0;
    end else begin
      if (hold_q == '0) begin
        v_cb <= cb_q; v_sec <= sec_q; v_min <= min_q; v_hr <= hr_q;
        v_dow <= dow_q; v_date <= date_q; v_mon <= mon_q; v_yr <= yr_q;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: v_sec <= wr_data[6:0];
          3'd1: v_min <= wr_data[6:0];
          3'd2: begin v_cb <= wr_data[6]; v_hr <= wr_data[5:0]; end
          3'd3: v_dow <= wr_data[2:0];
          3'd4: v_date <= wr_data[5:0];
          3'd5: v_mon <= wr_data[4:0];
          3'd6: v_yr <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {st_q, v_sec};
      3'd1:    rd_data = {1'b0, v_min};
      3'd2:    rd_data = {ceb_q, v_cb, v_hr};
      3'd3:    rd_data = {5'b0, v_dow};
      3'd4:    rd_data = {2'b0, v_date};
      3'd5:    rd_data = {3'b0, v_mon};
      3'd6:    rd_data = v_yr;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_chk #(
  parameter int HOLD_CNT = 250,
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_1hz,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic          st,
  input logic          ceb,
  input logic          cb,
  input logic [6:0]    sec,
  input logic [6:0]    min,
  input logic [HW-1:0] hold,
  input logic [6:0]    v_sec,
  input logic [7:0]    v_yr
);
  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st && !wr_en) |=> ($stable(sec) && $stable(min)));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !st && !wr_en && sec == 7'h59) |=> (sec == 7'h00));

  p_vis_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold != '0 && !wr_en) |=> ($stable(v_sec) && $stable(v_yr)));

  p_hold_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(hold) <= HOLD_CNT);

  p_cb_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceb && !wr_en) |=> $stable(cb));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (sec == $past(wr_data[6:0])));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk #(.HOLD_CNT(HOLD_CNT), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .st(st_q), .ceb(ceb_q), .cb(cb_q),
  .sec(sec_q), .min(min_q), .hold(hold_q), .v_sec(v_sec), .v_yr(v_yr)
);

// File: tb/sim_rtc_bcd_calendar.sv
`timescale 1ns/1ps
module sim_rtc_bcd_calendar;
  localparam int HOLD = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_1hz = 0, msec_ce = 0, rd_busy = 0, wr_en = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic phase_rst;
  int checks = 0, errors = 0;
  int ms, mm, mh, mw, md, mmo, my, mceb, mcb;

  rtc_bcd_calendar #(.HOLD_CNT(HOLD)) u0 (.*);

  always #2.5 clk = ~clk;

  function automatic int bcd(input int x);
    return ((x / 10) << 4) | (x % 10);
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic m_tick();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = (mw == 7) ? 1 : mw + 1; md++;
          if (md > dim(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin
              mmo = 1; my++;
              if (my == 100) begin my = 0; if (mceb != 0) mcb = 1 - mcb; end
            end
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 3'(a);
    #0.5;
    v = int'(rd_data);
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    @(negedge clk);
  endtask

  task automatic ms_pulse();
    @(negedge clk); msec_ce = 1;
    @(negedge clk); msec_ce = 0;
  endtask

  task automatic load_model();
    wr(0, bcd(ms)); wr(1, bcd(mm)); wr(2, (mceb << 7) | (mcb << 6) | bcd(mh));
    wr(3, mw); wr(4, bcd(md)); wr(5, bcd(mmo)); wr(6, bcd(my));
  endtask

  task automatic cmp_all(input string tag);
    int v;
    rd(0, v); chk({tag, " R3 sec"}, v, bcd(ms));
    rd(1, v); chk({tag, " R3 min"}, v, bcd(mm));
    rd(2, v); chk({tag, " R7 hr/century"}, v, (mceb << 7) | (mcb << 6) | bcd(mh));
    rd(3, v); chk({tag, " R4 dow"}, v, mw);
    rd(4, v); chk({tag, " R4 date"}, v, bcd(md));
    rd(5, v); chk({tag, " R6 month"}, v, bcd(mmo));
    rd(6, v); chk({tag, " R6 year"}, v, bcd(my));
  endtask

  task automatic set_model(input int s, input int m, input int h, input int w,
                           input int d, input int mo, input int y, input int ce, input int c);
    ms = s; mm = m; mh = h; mw = w; md = d; mmo = mo; my = y; mceb = ce; mcb = c;
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    set_model(0, 0, 0, 1, 1, 1, 0, 0, 0);
    cmp_all("R1 reset");

    // R2 field masks, address 7 ignored, phase_rst
    @(negedge clk);
    wr_en = 1; wr_addr = 3'd3; wr_data = 8'hFD;
    #0.5 chk("R10 phase_rst on write", int'(phase_rst), 1);
    @(negedge clk); wr_en = 0;
    rd(3, v); chk("R2 dow masked", v, 8'h05);
    wr(0, 8'h17);
    wr(7, 8'hFF);
    rd(7, v); chk("R2 addr7 reads 0", v, 0);
    rd(0, v); chk("R2 addr7 write no effect", v, 8'h17);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'd7; wr_data = 8'h00;
    #0.5 chk("R10 phase_rst low for addr7", int'(phase_rst), 0);
    @(negedge clk); wr_en = 0;
    #0.5 chk("R10 phase_rst idle", int'(phase_rst), 0);

    // R11 latency: one edge after tick not yet visible, two edges visible
    wr(0, 8'h30);
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    rd(0, v); chk("R11 not yet visible", v, 8'h30);
    @(negedge clk);
    rd(0, v); chk("R11 visible after two edges", v, 8'h31);

    // R10 write wins over same-cycle tick
    @(negedge clk);
    wr_en = 1; wr_addr = 3'd0; wr_data = 8'h45; tick_1hz = 1;
    @(negedge clk); wr_en = 0; tick_1hz = 0;
    @(negedge clk);
    rd(0, v); chk("R10 tick dropped on write", v, 8'h45);

    // R8 stop bit
    wr(0, 8'hA0);
    tick(); tick(); tick();
    rd(0, v); chk("R8 stopped seconds", v, 8'hA0);
    wr(0, 8'h20);
    tick();
    rd(0, v); chk("R8 restarted", v, 8'h21);

    // R7 century toggles with enable
    set_model(59, 59, 23, 7, 31, 12, 99, 1, 1);
    load_model(); tick(); m_tick();
    cmp_all("R7 cen_en=1");
    rd(2, v); chk("R7 century inverted", v, 8'h80);
    set_model(59, 59, 23, 7, 31, 12, 99, 0, 1);
    load_model(); tick(); m_tick();
    rd(2, v); chk("R7 century held", v, 8'h40);

    // R5 leap years
    set_model(59, 59, 23, 3, 28, 2, 24, 0, 0);
    load_model(); tick(); m_tick();
    rd(4, v); chk("R5 leap 24 feb29", v, 8'h29);
    set_model(59, 59, 23, 3, 28, 2, 23, 0, 0);
    load_model(); tick(); m_tick();
    rd(5, v); chk("R5 non-leap to march", v, 8'h03);
    set_model(59, 59, 23, 3, 28, 2, 0, 0, 0);
    load_model(); tick(); m_tick();
    rd(4, v); chk("R5 year 00 leap", v, 8'h29);
    set_model(59, 59, 23, 3, 29, 2, 12, 0, 0);
    load_model(); tick(); m_tick();
    cmp_all("R5 feb29 wrap");

    // R4 thirty-day month
    set_model(59, 59, 23, 2, 30, 4, 50, 0, 0);
    load_model(); tick(); m_tick();
    cmp_all("R4 april end");

    // R9 read hold-off
    set_model(10, 0, 0, 1, 1, 1, 0, 0, 0);
    load_model();
    @(negedge clk); rd_busy = 1;
    tick(); tick();
    rd_busy = 0;
    rd(0, v); chk("R9 frozen during hold", v, 8'h10);
    repeat (HOLD - 1) ms_pulse();
    @(negedge clk); @(negedge clk);
    rd(0, v); chk("R9 frozen one pulse short", v, 8'h10);
    ms_pulse();
    @(negedge clk); @(negedge clk);
    rd(0, v); chk("R9 both ticks shown after hold", v, 8'h12);

    // Random loads near and away from rollovers
    for (int it = 0; it < 40; it++) begin
      bit edge_case = ($urandom % 2) == 1;
      mmo = 1 + ($urandom % 12);
      my = $urandom % 100;
      mw = 1 + ($urandom % 7);
      mceb = $urandom % 2; mcb = $urandom % 2;
      if (edge_case) begin
        ms = 59; mm = 59; mh = 23; md = dim(mmo, my);
        if (($urandom % 4) == 0) begin mmo = 12; md = 31; my = ($urandom % 2) ? 99 : my; end
      end else begin
        ms = $urandom % 60; mm = $urandom % 60; mh = $urandom % 24;
        md = 1 + ($urandom % dim(mmo, my));
      end
      load_model();
      for (int k = 0; k < 1 + int'($urandom % 4); k++) begin
        tick(); m_tick();
      end
      cmp_all("rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule